// File: doc/BRIEF.md
# Special-Register Semaphore Unit

This block holds a small bank of binary semaphores that live in a special-register address space rather than in memory. A core acquires a semaphore with a "get" instruction and releases it with a "put" instruction. Each core's decoder presents a request with a special-register address and an operation. The block accepts the request and holds the decoder stalled for a fixed number of cycles. It then returns a one-bit grant flag on the result bus for the instruction's destination register, together with a completion pulse.

The block has no connection to the load/store path, so memory traffic continues at full rate while a semaphore operation is in flight. The semaphore index is the request address minus a programmable base register. An address whose offset falls outside the bank raises a trap and leaves every semaphore untouched. Software can therefore move the base so that all accesses trap, and emulate the semaphores in the kernel. Two cores share the bank. When both are accepted in the same cycle, core 0's operation takes effect before core 1's.

Top module: `sr_sema_unit`

## Requirements
- R1: After reset every semaphore is free, both `req_ready` bits are 1, and no `rsp_done` or `rsp_trap` bit is set.
- R2: The semaphore index is `req_addr - base`, computed modulo 2^AW. The access is in range when this offset is below N_SEM (offsets 0 to 15 by default). An address one below the base, or the base plus N_SEM, is out of range.
- R3: A get (`req_put`=0) to a free, in-range semaphore marks it taken and returns `rsp_data`=1.
- R4: A get to a taken semaphore returns `rsp_data`=0 and leaves the semaphore taken.
- R5: A put (`req_put`=1) to an in-range semaphore frees it and returns `rsp_data`=0, whether or not it was taken.
- R6: An out-of-range access completes with `rsp_trap`=1 and `rsp_data`=0 in its done cycle, and changes no semaphore.
- R7: Pulsing `base_we` loads `base_in` into the base register at the clock edge. A request accepted at that same edge uses the old base.
- R8: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 until the done cycle has passed. `rsp_done` is high for exactly one cycle, the third cycle after the request cycle (latency LAT=3). `rsp_trap` is never 1 outside a done cycle.
- R9: When both cores are accepted in the same cycle with a get to the same free semaphore, core 0 receives 1 and core 1 receives 0.
- R10: When both cores are accepted in the same cycle, core 1 observes the state after core 0's operation. A put by core 0 and a get by core 1 to the same taken semaphore give core 1 a grant of 1.
- R11: Gets from the two cores in the same cycle to different free semaphores are both granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the base register |
| base_in | input | AW | New base value |
| req_valid | input | 2 | Request present, one bit per core |
| req_ready | output | 2 | Core's decoder may issue; 0 means stalled |
| req_put | input | 2 | Operation per core: 1 = put, 0 = get |
| req_addr | input | 2 x AW | Special-register address per core |
| rsp_done | output | 2 | One-cycle completion pulse per core |
| rsp_data | output | 2 x DW | Grant flag for the destination register, valid with done |
| rsp_trap | output | 2 | Out-of-range access, valid with done |

## Verification
The bound checker checks the following on every cycle: the stall after acceptance, the exact latency and single-cycle width of the done pulse, that a trap only appears in a done cycle with zero data, and that the result never carries anything but a single flag bit. Which core wins a contested get, and the ordering within one cycle, depend on the stored semaphore state, so only the bench's scenarios show them. The same holds for the effect of the base register and for a trap leaving the bank untouched. The bench compares every response against a model of the bank kept in its scoreboard.

// File: rtl/sr_sema_unit.sv
module sr_sema_unit #(
  parameter int N_SEM = 16,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int LAT = 3,
  parameter logic [AW-1:0] BASE_RST = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 base_we,
  input  logic [AW-1:0]        base_in,
  input  logic [1:0]           req_valid,
  output logic [1:0]           req_ready,
  input  logic [1:0]           req_put,
  input  logic [1:0][AW-1:0]   req_addr,
  output logic [1:0]           rsp_done,
  output logic [1:0][DW-1:0]   rsp_data,
  output logic [1:0]           rsp_trap
);
  localparam int IW = (N_SEM > 1) ? $clog2(N_SEM) : 1;
  localparam int CW = $clog2(LAT);
  localparam logic [AW:0] NS = (AW+1)'(N_SEM);
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic [N_SEM-1:0] sem, sem_nxt;
  logic [AW-1:0] base;
  logic [1:0] busy, res_bit, res_trap, acc, inr, grant;
  logic [1:0][CW-1:0] cnt;
  logic [1:0][AW-1:0] off;

  assign acc = req_valid & req_ready;
  assign req_ready = ~busy;

  always_comb begin
    sem_nxt = sem;
    grant = '0;
    for (int c = 0; c < 2; c++) begin
      off[c] = req_addr[c] - base;
      inr[c] = {1'b0, off[c]} < NS;
      if (acc[c] && inr[c]) begin
        if (req_put[c]) begin
          sem_nxt[off[c][IW-1:0]] = 1'b0;
        end else begin
          grant[c] = ~sem_nxt[off[c][IW-1:0]];
          sem_nxt[off[c][IW-1:0]] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sem <= '0;
      base <= BASE_RST;
      busy <= '0;
      cnt <= '0;
      res_bit <= '0;
      res_trap <= '0;
    end else begin
      sem <= sem_nxt;
      if (base_we) base <= base_in;
      for (int c = 0; c < 2; c++) begin
        if (acc[c]) begin
          busy[c] <= 1'b1;
          cnt[c] <= CNT_INIT;
          res_bit[c] <= grant[c];
          res_trap[c] <= ~inr[c];
        end else if (busy[c]) begin
          if (cnt[c] == '0) busy[c] <= 1'b0;
          else cnt[c] <= cnt[c] - 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_rsp
      assign rsp_done[g] = busy[g] && (cnt[g] == '0);
      assign rsp_data[g] = {{(DW-1){1'b0}}, res_bit[g] & rsp_done[g]};
      assign rsp_trap[g] = res_trap[g] & rsp_done[g];
    end
  endgenerate
endmodule

// File: rtl/sr_sema_unit_chk.sv
module sr_sema_unit_chk #(
  parameter int DW = 8,
  parameter int LAT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         req_valid,
  input logic [1:0]         req_ready,
  input logic [1:0]         rsp_done,
  input logic [1:0][DW-1:0] rsp_data,
  input logic [1:0]         rsp_trap
);
  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_core
      logic live;
      int age;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live <= 1'b0;
          age <= 0;
        end else if (req_valid[c] && req_ready[c]) begin
          live <= 1'b1;
          age <= 0;
        end else if (live) begin
          if (rsp_done[c]) live <= 1'b0;
          if (age < 1000) age <= age + 1;
        end
      end

      AST_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[c] && req_ready[c]) |=> !req_ready[c]); // R8
      AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done[c] |-> (live && age == LAT - 1)); // R8
      AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done[c] |=> !rsp_done[c]); // R8
      AST_TRAP_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap[c] |-> rsp_done[c]); // R6
      AST_TRAP_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap[c] |-> (rsp_data[c] == '0)); // R6
      AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data[c] <= DW'(1)); // R3
    end
  endgenerate
endmodule

bind sr_sema_unit sr_sema_unit_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_trap(rsp_trap)
);

// File: tb/sim_sr_sema_unit.sv
module sim_sr_sema_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, base_we = 0;
  logic [7:0] base_in = '0;
  logic [1:0] req_valid = '0, req_put = '0;
  logic [1:0][7:0] req_addr = '0;
  logic [1:0] req_ready, rsp_done, rsp_trap;
  logic [1:0][7:0] rsp_data;

  sr_sema_unit u0 (.clk(clk), .rst_n(rst_n), .base_we(base_we), .base_in(base_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_put(req_put), .req_addr(req_addr),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_trap(rsp_trap));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] data; logic trap; int when; string tag; } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] m_sem = '0;
  logic [7:0] m_base = 8'h40;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(bit put, logic [7:0] a, string tag);
    exp_t e;
    logic [7:0] off;
    off = a - m_base;
    e.tag = tag; e.data = 0; e.trap = 0; e.when = 0;
    if (off >= 16) e.trap = 1;
    else if (put) m_sem[off[3:0]] = 1'b0;
    else begin
      e.data = {7'd0, ~m_sem[off[3:0]]};
      m_sem[off[3:0]] = 1'b1;
    end
    return e;
  endfunction

  task automatic issue(bit u0v, bit p0, logic [7:0] a0, bit u1v, bit p1, logic [7:0] a1,
                       bit wb, logic [7:0] nb, string tag);
    exp_t e0, e1;
    @(negedge clk);
    req_valid = {u1v, u0v}; req_put = {p1, p0}; req_addr[0] = a0; req_addr[1] = a1;
    base_we = wb; base_in = nb;
    if (u0v) e0 = model(p0, a0, tag);
    if (u1v) e1 = model(p1, a1, tag);
    if (wb) m_base = nb;
    @(posedge clk); #1;
    if (u0v) begin e0.when = cyc + 2; q0.push_back(e0); end
    if (u1v) begin e1.when = cyc + 2; q1.push_back(e1); end
    @(negedge clk);
    req_valid = '0; base_we = 0;
    check((req_ready & {u1v, u0v}) == 2'b00, "R8", "ready during stall", req_ready, 0);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rst_n && rsp_done[c]) begin
        exp_t e;
        if ((c == 0 ? q0.size() : q1.size()) == 0) begin
          check(0, "R8", "unexpected done", 1, 0);
        end else begin
          e = (c == 0) ? q0.pop_front() : q1.pop_front();
          check(rsp_data[c] == e.data, e.tag, "data", rsp_data[c], e.data);
          check(rsp_trap[c] == e.trap, e.tag, "trap", rsp_trap[c], e.trap);
          check(cyc == e.when, "R8", "done cycle", cyc, e.when);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 2'b11, "R1", "ready after reset", req_ready, 3);
    check(rsp_done == 2'b00, "R1", "done after reset", rsp_done, 0);
    check(rsp_trap == 2'b00, "R1", "trap after reset", rsp_trap, 0);
    issue(1, 0, 8'h43, 0, 0, 0, 0, 0, "R3");
    issue(1, 0, 8'h43, 0, 0, 0, 0, 0, "R4");
    issue(0, 0, 0, 1, 0, 8'h43, 0, 0, "R4");
    issue(1, 1, 8'h43, 0, 0, 0, 0, 0, "R5");
    issue(1, 1, 8'h43, 0, 0, 0, 0, 0, "R5");
    issue(0, 0, 0, 1, 0, 8'h43, 0, 0, "R3");
    issue(1, 0, 8'h3F, 0, 0, 0, 0, 0, "R2");
    issue(1, 0, 8'h50, 0, 0, 0, 0, 0, "R2");
    issue(1, 0, 8'h4F, 0, 0, 0, 0, 0, "R2");
    issue(0, 0, 0, 1, 1, 8'h90, 0, 0, "R6");
    issue(1, 0, 8'h40, 0, 0, 0, 0, 0, "R6");
    issue(1, 0, 8'h45, 1, 0, 8'h45, 0, 0, "R9");
    issue(1, 1, 8'h45, 1, 0, 8'h45, 0, 0, "R10");
    issue(1, 0, 8'h46, 1, 0, 8'h48, 0, 0, "R11");
    issue(1, 0, 8'h47, 0, 0, 0, 1, 8'h10, "R7");
    issue(1, 0, 8'h17, 0, 0, 0, 0, 0, "R7");
    issue(0, 0, 0, 1, 0, 8'h47, 0, 0, "R7");
    issue(1, 1, 8'h17, 1, 0, 8'h1F, 0, 0, "R10");
    repeat (6) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R8", "missing done", q0.size() + q1.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule